// File: doc/BRIEF.md
# Outbound Local-Bus to PCI Address Translator

This block sits behind a local memory-mapped slave port and turns each read or write it receives into one outbound PCI request descriptor. The top bits of the local address pick one page entry from a small translation table. The entry supplies the upper bits of the PCI address and names the target space: memory, I/O or configuration. The low local address bits pass straight through into the PCI address. The command code follows from the space and the transfer direction. Every space gets the same address formation and the same burst handling.

A build-time parameter sets how the table behaves. In fixed mode the entries are constants. In writable mode software programs the entries through a separate register port. The same port exposes a status word that shows whether a request is in flight and whether the PCI side has reported an error.

Only one request is handled at a time. The local master is held with waitrequest until the downstream engine takes the descriptor. Further requests wait until the PCI side signals completion.

Top module: `busToPciXlate`

## Requirements
- R1: While idle, a read or write request (`reqRead` or `reqWrite` high; write wins if both) is captured at the next clock edge, and `descValid` rises in the cycle after that edge.
- R2: `descAddr` is the selected entry's upper field followed by the low `LOCAL_AW-PAGE_BITS` local address bits, which are copied unchanged. The entry index is the top `PAGE_BITS` bits of `reqAddr`.
- R3: The entry space code (00 memory, 01 I/O, 10 configuration, 11 handled as memory) and the direction give `descCmd`: memory 0110 read / 0111 write, I/O 0010 / 0011, configuration 1010 / 1011.
- R4: `descBurst` equals the captured `reqBurst` for every space, configuration space included.
- R5: `reqWait` stays high except in the cycle where `descValid` and `descReady` are both high. While the descriptor waits for `descReady`, its contents do not change.
- R6: Status bit 0 (busy) is high from the capture edge until the edge where `pciDone` arrives after the descriptor was taken. No new request is captured while busy.
- R7: In writable mode, register index i (below `NUM_PAGES`) holds entry i: the upper PCI bits at positions `[PCI_AW-1:LOCAL_AW-PAGE_BITS]` and the space code at bits [1:0]. All other bits read as 0. A write changes only requests captured after the write's edge, so a request captured on the same edge still sees the old entry.
- R8: In fixed mode, entry i has upper field `FIXED_BASE+i` and space code `i mod 3`. Register writes to it have no effect and reads return these constants.
- R9: Status bit 1 (error) sets on a `pciError` pulse and stays set. Writing 1 to bit 1 clears it and writing 0 leaves it. A set in the same cycle as a clear wins.
- R10: After reset, `descValid` is low, `reqWait` is high, the status word is 0 and every writable entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqRead | input | 1 | Local read request |
| reqWrite | input | 1 | Local write request |
| reqAddr | input | LOCAL_AW | Local address |
| reqBurst | input | BURST_W | Local burst count |
| reqWait | output | 1 | Waitrequest back to the local master |
| descValid | output | 1 | Descriptor offered downstream |
| descReady | input | 1 | Downstream takes the descriptor |
| descAddr | output | PCI_AW | Translated PCI address |
| descCmd | output | 4 | PCI command code |
| descBurst | output | BURST_W | Burst count passed through |
| pciDone | input | 1 | PCI side finished the request |
| pciError | input | 1 | PCI side error pulse |
| regWrite | input | 1 | Register port write strobe |
| regRead | input | 1 | Register port read strobe |
| regAddr | input | PAGE_BITS+1 | Register index; index NUM_PAGES is status |
| regWdata | input | PCI_AW | Register write data |
| regRdata | output | PCI_AW | Register read data (0 when not reading) |

## Verification
A vector walk sends requests into every page with both directions and varied bursts. Each page pairs with a different space, including the reserved code, so a wrong index, a swapped command bit or a clipped pass-through field shows up in the address or command of a specific vector. One request stalls on `descReady` and one is offered while another is still in flight, which separates waitrequest and busy timing from plain translation. A writable and a fixed instance run the same stimulus. Entry writes issued on the same edge as a capture, and error set/clear collisions, pin down which edge each update lands on.

// File: rtl/xlatePkg.sv
package xlatePkg;

  typedef enum logic [1:0] {
    SP_MEM = 2'b00,
    SP_IO  = 2'b01,
    SP_CFG = 2'b10,
    SP_RSV = 2'b11
  } spaceT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OFFER,
    ST_WAIT
  } ctrlStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
  } ctrlStrobeT;

  function automatic logic [3:0] encodeCmd(input logic [1:0] space, input logic isWrite);
    logic [1:0] cls;
    case (space)
      SP_IO:   cls = 2'b00;
      SP_CFG:  cls = 2'b10;
      default: cls = 2'b01;
    endcase
    return {cls, 1'b1, isWrite};
  endfunction

endpackage

// File: rtl/xlateTable.sv
module xlateTable #(
  parameter int LOCAL_AW   = 16,
  parameter int PAGE_BITS  = 2,
  parameter int PCI_AW     = 32,
  parameter bit DYNAMIC    = 1'b1,
  parameter int FIXED_BASE = 'h100,
  localparam int PASS_W    = LOCAL_AW - PAGE_BITS,
  localparam int UPPER_W   = PCI_AW - PASS_W,
  localparam int NUM_PAGES = 1 << PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [PAGE_BITS-1:0] wrIdx,
  input  logic [PCI_AW-1:0]    wrData,
  input  logic [PAGE_BITS-1:0] lookIdx,
  output logic [UPPER_W-1:0]   lookUpper,
  output logic [1:0]           lookSpace,
  input  logic [PAGE_BITS-1:0] rdIdx,
  output logic [PCI_AW-1:0]    rdData
);

  logic [UPPER_W-1:0] upperArr [NUM_PAGES];
  logic [1:0]         spaceArr [NUM_PAGES];

  generate
    if (DYNAMIC) begin : gDyn
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < NUM_PAGES; i++) begin
            upperArr[i] <= '0;
            spaceArr[i] <= '0;
          end
        end else if (wrEn) begin
          upperArr[wrIdx] <= wrData[PCI_AW-1:PASS_W];
          spaceArr[wrIdx] <= wrData[1:0];
        end
      end
      logic unusedFixed;
      assign unusedFixed = ^wrData[PASS_W-1:2];
    end else begin : gFix
      always_comb begin
        for (int i = 0; i < NUM_PAGES; i++) begin
          upperArr[i] = UPPER_W'(FIXED_BASE + i);
          spaceArr[i] = 2'(i % 3);
        end
      end
      logic unusedWr;
      assign unusedWr = ^{clk, rstN, wrEn, wrIdx, wrData};
    end
  endgenerate

  assign lookUpper = upperArr[lookIdx];
  assign lookSpace = spaceArr[lookIdx];
  assign rdData    = {upperArr[rdIdx], {(PASS_W-2){1'b0}}, spaceArr[rdIdx]};

endmodule

// File: rtl/xlateData.sv
module xlateData
  import xlatePkg::*;
#(
  parameter int LOCAL_AW   = 16,
  parameter int PAGE_BITS  = 2,
  parameter int PCI_AW     = 32,
  parameter int BURST_W    = 4,
  parameter bit DYNAMIC    = 1'b1,
  parameter int FIXED_BASE = 'h100,
  localparam int PASS_W    = LOCAL_AW - PAGE_BITS,
  localparam int UPPER_W   = PCI_AW - PASS_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobeT           strobe,
  input  logic                 busy,
  input  logic                 reqWrite,
  input  logic [LOCAL_AW-1:0]  reqAddr,
  input  logic [BURST_W-1:0]   reqBurst,
  input  logic                 pciError,
  input  logic                 regWrite,
  input  logic                 regRead,
  input  logic [PAGE_BITS:0]   regAddr,
  input  logic [PCI_AW-1:0]    regWdata,
  output logic [PCI_AW-1:0]    descAddr,
  output logic [3:0]           descCmd,
  output logic [BURST_W-1:0]   descBurst,
  output logic [PCI_AW-1:0]    regRdata,
  output logic                 errFlag
);

  logic                isStatus;
  logic [UPPER_W-1:0]  lookUpper;
  logic [1:0]          lookSpace;
  logic [PCI_AW-1:0]   entryRd;

  assign isStatus = regAddr[PAGE_BITS];

  xlateTable #(
    .LOCAL_AW(LOCAL_AW), .PAGE_BITS(PAGE_BITS), .PCI_AW(PCI_AW),
    .DYNAMIC(DYNAMIC), .FIXED_BASE(FIXED_BASE)
  ) table_i (
    .clk(clk), .rstN(rstN),
    .wrEn(regWrite && !isStatus),
    .wrIdx(regAddr[PAGE_BITS-1:0]),
    .wrData(regWdata),
    .lookIdx(reqAddr[LOCAL_AW-1:PASS_W]),
    .lookUpper(lookUpper),
    .lookSpace(lookSpace),
    .rdIdx(regAddr[PAGE_BITS-1:0]),
    .rdData(entryRd)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr  <= '0;
      descCmd   <= '0;
      descBurst <= '0;
    end else if (strobe.capture) begin
      descAddr  <= {lookUpper, reqAddr[PASS_W-1:0]};
      descCmd   <= encodeCmd(lookSpace, reqWrite);
      descBurst <= reqBurst;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                errFlag <= 1'b0;
    else if (pciError)                        errFlag <= 1'b1;
    else if (regWrite && isStatus && regWdata[1]) errFlag <= 1'b0;
  end

  always_comb begin
    regRdata = '0;
    if (regRead) begin
      if (isStatus) regRdata = {{(PCI_AW-2){1'b0}}, errFlag, busy};
      else          regRdata = entryRd;
    end
  end

endmodule

// File: rtl/xlateCtrl.sv
module xlateCtrl
  import xlatePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqRead,
  input  logic       reqWrite,
  input  logic       descReady,
  input  logic       pciDone,
  output ctrlStrobeT strobe,
  output logic       descValid,
  output logic       reqWait,
  output logic       busy
);

  ctrlStateT state, stateNext;

  always_comb begin
    stateNext      = state;
    strobe.capture = 1'b0;
    reqWait        = 1'b1;
    case (state)
      ST_IDLE: begin
        if (reqRead || reqWrite) begin
          strobe.capture = 1'b1;
          stateNext      = ST_OFFER;
        end
      end
      ST_OFFER: begin
        if (descReady) begin
          reqWait   = 1'b0;
          stateNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (pciDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign descValid = (state == ST_OFFER);
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/busToPciXlate.sv
module busToPciXlate
  import xlatePkg::*;
#(
  parameter int LOCAL_AW   = 16,
  parameter int PAGE_BITS  = 2,
  parameter int PCI_AW     = 32,
  parameter int BURST_W    = 4,
  parameter bit DYNAMIC    = 1'b1,
  parameter int FIXED_BASE = 'h100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqRead,
  input  logic                 reqWrite,
  input  logic [LOCAL_AW-1:0]  reqAddr,
  input  logic [BURST_W-1:0]   reqBurst,
  output logic                 reqWait,
  output logic                 descValid,
  input  logic                 descReady,
  output logic [PCI_AW-1:0]    descAddr,
  output logic [3:0]           descCmd,
  output logic [BURST_W-1:0]   descBurst,
  input  logic                 pciDone,
  input  logic                 pciError,
  input  logic                 regWrite,
  input  logic                 regRead,
  input  logic [PAGE_BITS:0]   regAddr,
  input  logic [PCI_AW-1:0]    regWdata,
  output logic [PCI_AW-1:0]    regRdata
);

  ctrlStrobeT strobe;
  logic       statusBusy;
  logic       errFlag;

  xlateCtrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqRead(reqRead), .reqWrite(reqWrite),
    .descReady(descReady), .pciDone(pciDone),
    .strobe(strobe), .descValid(descValid),
    .reqWait(reqWait), .busy(statusBusy)
  );

  xlateData #(
    .LOCAL_AW(LOCAL_AW), .PAGE_BITS(PAGE_BITS), .PCI_AW(PCI_AW),
    .BURST_W(BURST_W), .DYNAMIC(DYNAMIC), .FIXED_BASE(FIXED_BASE)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(statusBusy),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqBurst(reqBurst),
    .pciError(pciError),
    .regWrite(regWrite), .regRead(regRead), .regAddr(regAddr),
    .regWdata(regWdata),
    .descAddr(descAddr), .descCmd(descCmd), .descBurst(descBurst),
    .regRdata(regRdata), .errFlag(errFlag)
  );

endmodule

// File: rtl/xlateChecker.sv
module xlateChecker #(
  parameter int PCI_AW  = 32,
  parameter int BURST_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqWait,
  input logic               descValid,
  input logic               descReady,
  input logic [PCI_AW-1:0]  descAddr,
  input logic [3:0]         descCmd,
  input logic [BURST_W-1:0] descBurst,
  input logic [BURST_W-1:0] reqBurst,
  input logic               pciDone,
  input logic               pciError,
  input logic               statusBusy,
  input logic               errFlag
);

  // R5: waitrequest drops only on the accepting cycle
  a_r5_wait_only_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    !reqWait |-> (descValid && descReady));

  // R5: an unaccepted descriptor is held unchanged
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && !descReady) |=> (descValid && $stable(descAddr)
                                   && $stable(descCmd) && $stable(descBurst)));

  // R4: burst count copied from the captured request
  a_r4_burst_copy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(descValid) |-> (descBurst == $past(reqBurst)));

  // R3: only the three legal command classes appear
  a_r3_cmd_class: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> (descCmd[1] && (descCmd[3:2] != 2'b11)));

  // R6: busy covers the offer phase
  a_r6_busy_during_offer: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> statusBusy);

  // R6: completion ends busy
  a_r6_busy_ends: assert property (@(posedge clk) disable iff (!rstN)
    (statusBusy && !descValid && pciDone) |=> !statusBusy);

  // R9: an error pulse always leaves the flag set
  a_r9_err_sets: assert property (@(posedge clk) disable iff (!rstN)
    pciError |=> errFlag);

endmodule

bind busToPciXlate xlateChecker #(.PCI_AW(PCI_AW), .BURST_W(BURST_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqWait(reqWait), .descValid(descValid),
  .descReady(descReady), .descAddr(descAddr), .descCmd(descCmd),
  .descBurst(descBurst), .reqBurst(reqBurst), .pciDone(pciDone),
  .pciError(pciError), .statusBusy(statusBusy), .errFlag(errFlag)
);

// File: tb/busToPciXlate_test.sv
module busToPciXlate_test;

  localparam int LOCAL_AW = 16;
  localparam int PAGE_BITS = 2;
  localparam int PCI_AW = 32;
  localparam int BURST_W = 4;
  localparam int FIXED_BASE = 'h100;
  localparam logic [PAGE_BITS:0] STATUS_IDX = 3'd4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqRead = 0, reqWrite = 0, descReady = 0, pciDone = 0, pciError = 0;
  logic [LOCAL_AW-1:0] reqAddr = '0;
  logic [BURST_W-1:0] reqBurst = '0;
  logic regWrite = 0, regRead = 0;
  logic [PAGE_BITS:0] regAddr = '0;
  logic [PCI_AW-1:0] regWdata = '0;

  logic reqWait, descValid, fReqWait, fDescValid;
  logic [PCI_AW-1:0] descAddr, regRdata, fDescAddr, fRegRdata;
  logic [3:0] descCmd, fDescCmd;
  logic [BURST_W-1:0] descBurst, fDescBurst;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  busToPciXlate #(.DYNAMIC(1'b1)) uut (
    .clk(clk), .rstN(rstN), .reqRead(reqRead), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBurst(reqBurst), .reqWait(reqWait),
    .descValid(descValid), .descReady(descReady), .descAddr(descAddr),
    .descCmd(descCmd), .descBurst(descBurst), .pciDone(pciDone),
    .pciError(pciError), .regWrite(regWrite), .regRead(regRead),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata));

  busToPciXlate #(.DYNAMIC(1'b0), .FIXED_BASE(FIXED_BASE)) fixedUut (
    .clk(clk), .rstN(rstN), .reqRead(reqRead), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBurst(reqBurst), .reqWait(fReqWait),
    .descValid(fDescValid), .descReady(descReady), .descAddr(fDescAddr),
    .descCmd(fDescCmd), .descBurst(fDescBurst), .pciDone(pciDone),
    .pciError(pciError), .regWrite(regWrite), .regRead(regRead),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(fRegRdata));

  typedef struct packed {
    logic [15:0] addr;
    logic        wr;
    logic [3:0]  burst;
    logic [31:0] expAddr;
    logic [3:0]  expCmd;
  } vecT;

  // writable table programmed with: page0 mem, page1 I/O, page2 cfg, page3 code 11
  localparam vecT VECS [8] = '{
    '{16'h0123, 1'b0, 4'd1,  32'hA000_0123, 4'b0110},
    '{16'h3FFF, 1'b1, 4'd4,  32'hA000_3FFF, 4'b0111},
    '{16'h4010, 1'b0, 4'd1,  32'h0000_4010, 4'b0010},
    '{16'h7ABC, 1'b1, 4'd2,  32'h0000_7ABC, 4'b0011},
    '{16'h8004, 1'b0, 4'd8,  32'h1234_4004, 4'b1010},
    '{16'hBFFC, 1'b1, 4'd15, 32'h1234_7FFC, 4'b1011},
    '{16'hC000, 1'b0, 4'd1,  32'hFFFF_C000, 4'b0110},
    '{16'hFFFF, 1'b1, 4'd3,  32'hFFFF_FFFF, 4'b0111}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] cmdFor(input int space, input logic wr);
    case (space)
      1: return {3'b001, wr};
      2: return {3'b101, wr};
      default: return {3'b011, wr};
    endcase
  endfunction

  function automatic logic [31:0] fixedEntry(input int i);
    return ((FIXED_BASE + i) << (LOCAL_AW - PAGE_BITS)) | (i % 3);
  endfunction

  task automatic regWr(input logic [PAGE_BITS:0] idx, input logic [31:0] d);
    @(negedge clk);
    regWrite = 1; regAddr = idx; regWdata = d;
    @(negedge clk);
    regWrite = 0;
  endtask

  task automatic regRd(input logic [PAGE_BITS:0] idx, output logic [31:0] d, output logic [31:0] fd);
    regRead = 1; regAddr = idx;
    #1;
    d = regRdata; fd = fRegRdata;
    regRead = 0;
  endtask

  task automatic runReq(input logic [15:0] a, input logic w, input logic [3:0] b,
                        input logic [31:0] expA, input logic [3:0] expC, input int stall);
    logic [31:0] st, fst, fexp;
    int page;
    page = int'(a[15:14]);
    fexp = ((FIXED_BASE + page) << 14) | {18'd0, a[13:0]};
    @(negedge clk);
    reqAddr = a; reqWrite = w; reqRead = !w; reqBurst = b;
    @(negedge clk);
    check(descValid === 1'b1, "R1 descValid after capture", 32'(descValid), 1);
    check(reqWait === 1'b1, "R5 wait held before ready", 32'(reqWait), 1);
    repeat (stall) @(negedge clk);
    descReady = 1;
    #1;
    check(reqWait === 1'b0, "R5 wait low on accept", 32'(reqWait), 0);
    check(descAddr === expA, "R2 address", descAddr, expA);
    check(descCmd === expC, "R3 command", 32'(descCmd), 32'(expC));
    check(descBurst === b, "R4 burst", 32'(descBurst), 32'(b));
    check(fDescAddr === fexp, "R8 fixed address", fDescAddr, fexp);
    check(fDescCmd === cmdFor(page % 3, w), "R8 fixed command", 32'(fDescCmd), 32'(cmdFor(page % 3, w)));
    @(negedge clk);
    reqRead = 0; reqWrite = 0; descReady = 0;
    regRd(STATUS_IDX, st, fst);
    check(st[0] === 1'b1, "R6 busy while awaiting done", st, 1);
    pciDone = 1;
    @(negedge clk);
    pciDone = 0;
    regRd(STATUS_IDX, st, fst);
    check(st[0] === 1'b0, "R6 busy cleared by done", st, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, fd;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    check(descValid === 1'b0, "R10 descValid reset", 32'(descValid), 0);
    check(reqWait === 1'b1, "R10 reqWait reset", 32'(reqWait), 1);
    regRd(STATUS_IDX, d, fd);
    check(d === 32'h0, "R10 status reset", d, 0);
    regRd(3'd2, d, fd);
    check(d === 32'h0, "R10 entry reset", d, 0);

    // R7 program the writable table
    regWr(3'd0, 32'hA000_0000);
    regWr(3'd1, 32'h0000_4001);
    regWr(3'd2, 32'h1234_4FFE);
    regWr(3'd3, 32'hFFFF_C003);
    @(negedge clk);
    regRd(3'd2, d, fd);
    check(d === 32'h1234_4002, "R7 readback masks unused bits", d, 32'h1234_4002);
    // R8 fixed instance ignored the writes
    for (int i = 0; i < 4; i++) begin
      regRd(3'(i), d, fd);
      check(fd === fixedEntry(i), "R8 fixed entry readback", fd, fixedEntry(i));
    end

    // main vector walk
    for (int v = 0; v < 8; v++)
      runReq(VECS[v].addr, VECS[v].wr, VECS[v].burst, VECS[v].expAddr, VECS[v].expCmd,
             (v == 4) ? 3 : 0);

    // R6 one outstanding: a new request waits during the completion phase
    @(negedge clk);
    reqAddr = 16'h4001; reqRead = 1; reqBurst = 4'd1;
    @(negedge clk);
    descReady = 1;
    @(negedge clk);
    descReady = 0;
    reqAddr = 16'h0002; reqRead = 0; reqWrite = 1; reqBurst = 4'd5;
    repeat (3) begin
      @(negedge clk);
      check(descValid === 1'b0, "R6 no second capture while busy", 32'(descValid), 0);
      check(reqWait === 1'b1, "R6 wait held while busy", 32'(reqWait), 1);
    end
    pciDone = 1;
    @(negedge clk);
    pciDone = 0;
    @(negedge clk);
    check(descValid === 1'b1, "R6 pending request taken after done", 32'(descValid), 1);
    check(descAddr === 32'hA000_0002, "R6 pending request address", descAddr, 32'hA000_0002);
    descReady = 1;
    @(negedge clk);
    descReady = 0; reqWrite = 0;
    pciDone = 1;
    @(negedge clk);
    pciDone = 0;

    // R7 write on the same edge as a capture uses the old entry
    @(negedge clk);
    regWrite = 1; regAddr = 3'd0; regWdata = 32'h5555_4000;
    reqAddr = 16'h0001; reqRead = 1; reqBurst = 4'd1;
    @(negedge clk);
    regWrite = 0;
    check(descAddr === 32'hA000_0001, "R7 same-edge write not seen", descAddr, 32'hA000_0001);
    descReady = 1;
    @(negedge clk);
    descReady = 0; reqRead = 0;
    pciDone = 1;
    @(negedge clk);
    pciDone = 0;
    runReq(16'h0001, 1'b0, 4'd1, 32'h5555_4001, 4'b0110, 0);

    // R9 error flag
    @(negedge clk);
    pciError = 1;
    @(negedge clk);
    pciError = 0;
    regRd(STATUS_IDX, d, fd);
    check(d[1] === 1'b1, "R9 error set", d, 2);
    regWr(STATUS_IDX, 32'h0000_0001);
    regRd(STATUS_IDX, d, fd);
    check(d[1] === 1'b1, "R9 write 0 to error keeps it", d, 2);
    @(negedge clk);
    regWrite = 1; regAddr = STATUS_IDX; regWdata = 32'h2; pciError = 1;
    @(negedge clk);
    regWrite = 0; pciError = 0;
    regRd(STATUS_IDX, d, fd);
    check(d[1] === 1'b1, "R9 set wins over clear", d, 2);
    regWr(STATUS_IDX, 32'h0000_0002);
    regRd(STATUS_IDX, d, fd);
    check(d === 32'h0, "R9 write 1 clears error", d, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule